// File: doc/BRIEF.md
# Debug Command Engine for a Scan-Controlled CPU

This block turns high-level debug requests into the scan transactions that a lower-level serial sequencer carries out against a small target CPU. The target holds a chain of shadow registers. A control byte in that chain can make the CPU's instruction decoder take its instruction from a shadow instruction word instead of the real one. By loading that shadow word with chosen instructions, the engine can write registers, write the instruction register, capture a snapshot of all registers, move words to and from main memory, and single-step the CPU.

A request carries an opcode, a register index, an 8-bit address and a 16-bit data word, and is accepted with a valid/ready handshake. For each sub-transaction the engine presents four phase flags and a full send vector to the sequencer, pulses a start strobe, and waits for the sequencer's done pulse. It takes result bytes from the sequencer's receive vector. When the last sub-transaction has finished, the engine pulses a response strobe carrying the result word and an error flag.

Memory is never touched directly. A memory write loads three CPU registers with address and data, then toggles the write-enable bit of the instruction word. A memory read loads the address, injects two memory-load instructions, and reads back the two loaded registers through the snapshot.

Top module: `dbg_cmd_engine`

## Requirements
- R1: Opcodes are 0 write register, 1 write instruction register, 2 read register, 3 write memory, 4 read memory, 5 step; opcodes 6 and 7 answer with rsp_err=1, rsp_data=0 and issue no transaction.
- R2: Write register issues one transaction with flags 4'b1110 (seq_flags[3] pre-CPU clock, [2] pre-shift pulse, [1] scan, [0] post-CPU clock), send byte 7 (bits 63:56) = 8'h02, byte 1 = 8'hA0 OR (index shifted left by 2), byte 0 = data[7:0], all other bytes zero.
- R3: Write instruction register issues one transaction with flags 4'b1110, byte 7 = 8'h06, byte 1 = data[15:8], byte 0 = data[7:0].
- R4: Read register issues one transaction with flags 4'b1110, byte 7 = 8'h02 and bytes 1 and 0 zero, and returns receive byte (6 − index) in rsp_data[7:0], upper byte zero; index 4 is the program counter, 5 and 6 the instruction word high and low halves.
- R5: Write memory issues five 4'b1110 transactions in order: load register 3 with the address, register 2 with data[15:8], register 1 with data[7:0] (each coded as in R2), then byte 1 = 8'h02, then byte 1 = 8'h00, the last two with byte 7 = 8'h02 and byte 0 zero.
- R6: Read memory issues five 4'b1110 transactions: load register 3 with the address, byte 1 = 8'hC8, byte 1 = 8'hC4, then two snapshot reads; rsp_data = {receive byte 4 of the fourth, receive byte 5 of the fifth}.
- R7: Step issues three transactions: flags 4'b0010 with an all-zero send vector, then flags 4'b0001 with an all-zero send vector, then flags 4'b0010 with only byte 7 = 8'h02.
- R8: Read or write register with index 7 answers with rsp_err=1 and issues no transaction.
- R9: cmd_ready falls in the cycle after acceptance and stays low until rsp_done; rsp_done is a one-cycle pulse and cmd_ready is high in the following cycle.
- R10: Whenever cmd_ready is high, seq_send and seq_flags are all zero and seq_start is low.
- R11: seq_start is a one-cycle pulse, and the next one comes only after seq_done for the previous transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Engine idle, request accepted when valid |
| cmd_op | input | 3 | Opcode |
| cmd_reg | input | 3 | Register index |
| cmd_addr | input | 8 | Memory address |
| cmd_data | input | 16 | Write data or instruction word |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected |
| rsp_data | output | 16 | Read result |
| seq_start | output | 1 | Start pulse to the sequencer |
| seq_flags | output | 4 | Phase flags {pre-CPU, pre-shift, scan, post-CPU} |
| seq_send | output | NUM_BYTES*8 | Send vector, byte k in bits 8k+7:8k |
| seq_done | input | 1 | Sequencer finished a transaction |
| seq_recv | input | NUM_BYTES*8 | Receive vector from the last transaction |

## Verification
The bench builds the engine with its default chain length of eight bytes, which is the length the control-byte and instruction-word positions assume. That size puts every register index, both rejected opcodes and every multi-transaction order within reach. The stand-in sequencer answers with a latency of one to three cycles, so sub-transactions are strung together with different gaps. Each read gets a fresh receive pattern, so every snapshot byte position shows up in a result.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int STEP_W    = 3;
  localparam int BYTE_CTRL = 7;
  localparam int BYTE_IRH  = 1;
  localparam int BYTE_IRL  = 0;

  localparam logic [7:0] CTRL_NONE = 8'h00;
  localparam logic [7:0] CTRL_OVR  = 8'h02;
  localparam logic [7:0] CTRL_IRW  = 8'h06;

  // phase flags {pre_cpu, pre_shift, scan, post_cpu}
  localparam logic [3:0] PH_LOAD = 4'b1110;
  localparam logic [3:0] PH_SCAN = 4'b0010;
  localparam logic [3:0] PH_POST = 4'b0001;

  typedef enum logic [2:0] {
    OP_WREG = 3'd0,
    OP_WIR  = 3'd1,
    OP_RREG = 3'd2,
    OP_WMEM = 3'd3,
    OP_RMEM = 3'd4,
    OP_STEP = 3'd5
  } op_e;

  typedef struct packed {
    logic [3:0] ph;
    logic [7:0] ctrl;
    logic [7:0] irh;
    logic [7:0] irl;
    logic       last;
    logic       cap_lo;
    logic       cap_hi;
    logic [2:0] cap_byte;
  } txn_t;
endpackage

// File: rtl/dbg_txn_plan.sv
module dbg_txn_plan
  import dbg_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [2:0]        reg_idx,
  input  logic [7:0]        addr,
  input  logic [15:0]       data,
  input  logic [STEP_W-1:0] step,
  output txn_t              txn
);
  function automatic txn_t load_imm(input logic [2:0] r, input logic [7:0] v);
    txn_t x;
    x      = '0;
    x.ph   = PH_LOAD;
    x.ctrl = CTRL_OVR;
    x.irh  = 8'hA0 | {3'b000, r, 2'b00};
    x.irl  = v;
    return x;
  endfunction

  function automatic txn_t inject(input logic [7:0] hi);
    txn_t x;
    x      = '0;
    x.ph   = PH_LOAD;
    x.ctrl = CTRL_OVR;
    x.irh  = hi;
    return x;
  endfunction

  always_comb begin
    txn = '0;
    unique case (op)
      OP_WREG: begin
        txn      = load_imm(reg_idx, data[7:0]);
        txn.last = 1'b1;
      end
      OP_WIR: begin
        txn.ph   = PH_LOAD;
        txn.ctrl = CTRL_IRW;
        txn.irh  = data[15:8];
        txn.irl  = data[7:0];
        txn.last = 1'b1;
      end
      OP_RREG: begin
        txn          = inject(8'h00);
        txn.cap_lo   = 1'b1;
        txn.cap_byte = 3'd6 - reg_idx;
        txn.last     = 1'b1;
      end
      OP_WMEM: begin
        case (step)
          3'd0:    txn = load_imm(3'd3, addr);
          3'd1:    txn = load_imm(3'd2, data[15:8]);
          3'd2:    txn = load_imm(3'd1, data[7:0]);
          3'd3:    txn = inject(8'h02);
          default: begin
            txn      = inject(8'h00);
            txn.last = 1'b1;
          end
        endcase
      end
      OP_RMEM: begin
        case (step)
          3'd0:    txn = load_imm(3'd3, addr);
          3'd1:    txn = inject(8'hC8);
          3'd2:    txn = inject(8'hC4);
          3'd3: begin
            txn          = inject(8'h00);
            txn.cap_hi   = 1'b1;
            txn.cap_byte = 3'd4;
          end
          default: begin
            txn          = inject(8'h00);
            txn.cap_lo   = 1'b1;
            txn.cap_byte = 3'd5;
            txn.last     = 1'b1;
          end
        endcase
      end
      OP_STEP: begin
        case (step)
          3'd0:    txn.ph = PH_SCAN;
          3'd1:    txn.ph = PH_POST;
          default: begin
            txn.ph   = PH_SCAN;
            txn.ctrl = CTRL_OVR;
            txn.last = 1'b1;
          end
        endcase
      end
      default: txn = '0;
    endcase
  end
endmodule

// File: rtl/dbg_capture.sv
module dbg_capture #(
  parameter int NUM_BYTES = 8,
  localparam int VEC_W = NUM_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cap_lo,
  input  logic             cap_hi,
  input  logic [2:0]       byte_sel,
  input  logic [VEC_W-1:0] recv,
  output logic [15:0]      result
);
  logic [7:0] picked;
  assign picked = recv[8*byte_sel +: 8];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      result <= '0;
    end else begin
      if (cap_lo) result[7:0]  <= picked;
      if (cap_hi) result[15:8] <= picked;
    end
  end

  assert_one_cap_R6: assert property (@(posedge clk) disable iff (rst)
    !(cap_lo && cap_hi));
endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int VEC_W = NUM_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [2:0]        cmd_reg,
  input  logic [7:0]        cmd_addr,
  input  logic [15:0]       cmd_data,
  input  txn_t              txn,
  output logic [2:0]        op_q,
  output logic [2:0]        reg_q,
  output logic [7:0]        addr_q,
  output logic [15:0]       data_q,
  output logic [STEP_W-1:0] step_q,
  output logic              cap_clr,
  output logic              cap_lo,
  output logic              cap_hi,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic              seq_start,
  output logic [3:0]        seq_flags,
  output logic [VEC_W-1:0]  seq_send,
  input  logic              seq_done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;
  state_e state;

  logic accept, reject, fin;
  logic [VEC_W-1:0] send_nxt;

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign reject    = (cmd_op > 3'd5) ||
                     ((cmd_op == OP_WREG || cmd_op == OP_RREG) && cmd_reg == 3'd7);
  assign fin       = (state == S_WAIT) && seq_done;
  assign cap_clr   = accept;
  assign cap_lo    = fin && txn.cap_lo;
  assign cap_hi    = fin && txn.cap_hi;

  always_comb begin
    send_nxt = '0;
    send_nxt[8*BYTE_CTRL +: 8] = txn.ctrl;
    send_nxt[8*BYTE_IRH  +: 8] = txn.irh;
    send_nxt[8*BYTE_IRL  +: 8] = txn.irl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      step_q    <= '0;
      op_q      <= '0;
      reg_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      rsp_done  <= 1'b0;
      rsp_err   <= 1'b0;
      seq_start <= 1'b0;
      seq_flags <= '0;
      seq_send  <= '0;
    end else begin
      seq_start <= 1'b0;
      rsp_done  <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          op_q    <= cmd_op;
          reg_q   <= cmd_reg;
          addr_q  <= cmd_addr;
          data_q  <= cmd_data;
          step_q  <= '0;
          rsp_err <= reject;
          if (reject) begin
            rsp_done <= 1'b1;
            state    <= S_RESP;
          end else begin
            state <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          seq_start <= 1'b1;
          seq_flags <= txn.ph;
          seq_send  <= send_nxt;
          state     <= S_WAIT;
        end
        S_WAIT: if (seq_done) begin
          if (txn.last) begin
            seq_send  <= '0;
            seq_flags <= '0;
            rsp_done  <= 1'b1;
            state     <= S_RESP;
          end else begin
            step_q <= step_q + 1'b1;
            state  <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> (!rsp_done && cmd_ready));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (seq_send == '0 && seq_flags == 4'd0 && !seq_start));
  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    seq_start |=> !seq_start);
  assert_reject_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && (cmd_op == OP_WREG || cmd_op == OP_RREG) && cmd_reg == 3'd7)
      |=> (rsp_done && rsp_err && !seq_start));
  assert_bad_op_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op > 3'd5) |=> (rsp_done && rsp_err));
  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    step_q < 3'd5);
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine
  import dbg_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int VEC_W = NUM_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [2:0]       cmd_op,
  input  logic [2:0]       cmd_reg,
  input  logic [7:0]       cmd_addr,
  input  logic [15:0]      cmd_data,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [15:0]      rsp_data,
  output logic             seq_start,
  output logic [3:0]       seq_flags,
  output logic [VEC_W-1:0] seq_send,
  input  logic             seq_done,
  input  logic [VEC_W-1:0] seq_recv
);
  txn_t              txn;
  logic [2:0]        op_q, reg_q;
  logic [7:0]        addr_q;
  logic [15:0]       data_q;
  logic [STEP_W-1:0] step_q;
  logic              cap_clr, cap_lo, cap_hi;

  dbg_txn_plan u_plan (
    .op(op_q), .reg_idx(reg_q), .addr(addr_q), .data(data_q),
    .step(step_q), .txn(txn)
  );

  dbg_seq_fsm #(.NUM_BYTES(NUM_BYTES)) u_fsm (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .txn(txn), .op_q(op_q), .reg_q(reg_q), .addr_q(addr_q), .data_q(data_q),
    .step_q(step_q), .cap_clr(cap_clr), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .rsp_done(rsp_done), .rsp_err(rsp_err),
    .seq_start(seq_start), .seq_flags(seq_flags), .seq_send(seq_send),
    .seq_done(seq_done)
  );

  dbg_capture #(.NUM_BYTES(NUM_BYTES)) u_cap (
    .clk(clk), .rst(rst), .clr(cap_clr), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .byte_sel(txn.cap_byte), .recv(seq_recv), .result(rsp_data)
  );

  assert_rsp_data_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_err) |-> rsp_data == 16'h0000);
endmodule

// File: tb/sim_dbg_cmd_engine.sv
module sim_dbg_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int VW = NB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [2:0] cmd_op = '0, cmd_reg = '0;
  logic [7:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic rsp_done, rsp_err;
  logic [15:0] rsp_data;
  logic seq_start;
  logic [3:0] seq_flags;
  logic [VW-1:0] seq_send;
  logic seq_done = 1'b0;
  logic [VW-1:0] seq_recv = '0;
  logic [VW-1:0] recv_pat = '0;

  int checks = 0;
  int errors = 0;
  int ntx = 0;

  logic [VW+3:0] exp_tx[$];
  logic [16:0]   exp_rsp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_engine #(.NUM_BYTES(NB)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .seq_start(seq_start), .seq_flags(seq_flags), .seq_send(seq_send),
    .seq_done(seq_done), .seq_recv(seq_recv)
  );

  task automatic check(input string tag, input logic [VW+3:0] act, input logic [VW+3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW+3:0] tx(input logic [3:0] f, input logic [7:0] c,
                                       input logic [7:0] h, input logic [7:0] l);
    logic [VW-1:0] v;
    v = '0;
    v[63:56] = c;
    v[15:8]  = h;
    v[7:0]   = l;
    return {f, v};
  endfunction

  function automatic logic [VW+3:0] ldi(input logic [2:0] r, input logic [7:0] v);
    return tx(4'b1110, 8'h02, 8'hA0 | {3'b000, r, 2'b00}, v);
  endfunction

  function automatic logic [7:0] rbyte(input int k);
    return recv_pat[8*k +: 8];
  endfunction

  // sequencer stand-in: checks each transaction against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && seq_start) begin
        logic [VW+3:0] e;
        string tg;
        tg = "R11";
        if (exp_tx.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected transaction actual=%h expected=none", {seq_flags, seq_send});
        end else begin
          e = exp_tx.pop_front();
          check("R2-R7 transaction", {seq_flags, seq_send}, e);
        end
        check("R9 ready low while busy", {{(VW+3){1'b0}}, cmd_ready}, '0);
        seq_recv = recv_pat;
        repeat (1 + (ntx % 3)) begin
          @(negedge clk);
          check(tg, {{(VW+3){1'b0}}, seq_start}, '0);
          tg = "R11 no restart before done";
        end
        ntx++;
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
      end
    end
  end

  // response monitor
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_done) begin
        if (exp_rsp.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9 unexpected response actual=%h expected=none", {rsp_err, rsp_data});
        end else begin
          check("R1/R4/R6/R8 response", {{(VW-13){1'b0}}, rsp_err, rsp_data},
                {{(VW-13){1'b0}}, exp_rsp.pop_front()});
        end
        @(negedge clk);
        check("R9 ready after response", {{(VW+3){1'b0}}, cmd_ready}, {{(VW+3){1'b0}}, 1'b1});
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [2:0] r,
                       input logic [7:0] a, input logic [15:0] d);
    while (!cmd_ready) @(negedge clk);
    check("R10 idle quiet", {seq_flags, seq_send}, '0);
    cmd_op = op; cmd_reg = r; cmd_addr = a; cmd_data = d;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R9 ready drops", {{(VW+3){1'b0}}, cmd_ready}, '0);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [2:0] r,
                        input logic [7:0] a, input logic [15:0] d);
    case (op)
      3'd0: if (r == 3'd7) exp_rsp.push_back(17'h10000);
            else begin exp_tx.push_back(ldi(r, d[7:0])); exp_rsp.push_back(17'h0); end
      3'd1: begin exp_tx.push_back(tx(4'b1110, 8'h06, d[15:8], d[7:0])); exp_rsp.push_back(17'h0); end
      3'd2: if (r == 3'd7) exp_rsp.push_back(17'h10000);
            else begin
              exp_tx.push_back(tx(4'b1110, 8'h02, 8'h00, 8'h00));
              exp_rsp.push_back({9'h0, rbyte(6 - int'(r))});
            end
      3'd3: begin
        exp_tx.push_back(ldi(3'd3, a));
        exp_tx.push_back(ldi(3'd2, d[15:8]));
        exp_tx.push_back(ldi(3'd1, d[7:0]));
        exp_tx.push_back(tx(4'b1110, 8'h02, 8'h02, 8'h00));
        exp_tx.push_back(tx(4'b1110, 8'h02, 8'h00, 8'h00));
        exp_rsp.push_back(17'h0);
      end
      3'd4: begin
        exp_tx.push_back(ldi(3'd3, a));
        exp_tx.push_back(tx(4'b1110, 8'h02, 8'hC8, 8'h00));
        exp_tx.push_back(tx(4'b1110, 8'h02, 8'hC4, 8'h00));
        exp_tx.push_back(tx(4'b1110, 8'h02, 8'h00, 8'h00));
        exp_tx.push_back(tx(4'b1110, 8'h02, 8'h00, 8'h00));
        exp_rsp.push_back({1'b0, rbyte(4), rbyte(5)});
      end
      3'd5: begin
        exp_tx.push_back(tx(4'b0010, 8'h00, 8'h00, 8'h00));
        exp_tx.push_back(tx(4'b0001, 8'h00, 8'h00, 8'h00));
        exp_tx.push_back(tx(4'b0010, 8'h02, 8'h00, 8'h00));
        exp_rsp.push_back(17'h0);
      end
      default: exp_rsp.push_back(17'h10000);
    endcase
    issue(op, r, a, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check("R9 reset ready", {{(VW+3){1'b0}}, cmd_ready}, {{(VW+3){1'b0}}, 1'b1});
    check("R10 reset outputs", {seq_flags, seq_send}, '0);
    check("R11 reset start", {{(VW+3){1'b0}}, seq_start}, '0);
    check("R9 reset done", {{(VW+3){1'b0}}, rsp_done}, '0);

    // R2: write every legal register
    for (int r = 0; r < 7; r++) do_cmd(3'd0, 3'(r), 8'h00, 16'hFF00 | 16'(r * 37));
    // R3
    do_cmd(3'd1, 3'd0, 8'h00, 16'hBEEF);
    do_cmd(3'd1, 3'd5, 8'h11, 16'h0180);
    // R4: read every legal register with fresh snapshots
    for (int r = 0; r < 7; r++) begin
      recv_pat = {8'h5A, 8'h10 + 8'(r), 8'h21, 8'h32, 8'h43, 8'h54, 8'h65, 8'h76} ^ {8{8'(r * 9)}};
      do_cmd(3'd2, 3'(r), 8'h00, 16'h0000);
    end
    // R5
    do_cmd(3'd3, 3'd0, 8'h5A, 16'h1234);
    do_cmd(3'd3, 3'd7, 8'hFF, 16'hA5C3);
    // R6
    recv_pat = 64'h0211_2233_4455_6677;
    do_cmd(3'd4, 3'd0, 8'h33, 16'h0000);
    recv_pat = 64'hFEDC_BA98_7654_3210;
    do_cmd(3'd4, 3'd2, 8'hC0, 16'hFFFF);
    // R7
    do_cmd(3'd5, 3'd0, 8'h00, 16'h0000);
    do_cmd(3'd5, 3'd3, 8'hAA, 16'h5555);
    // R8
    do_cmd(3'd0, 3'd7, 8'h00, 16'h00AA);
    do_cmd(3'd2, 3'd7, 8'h00, 16'h0000);
    // R1: unused opcodes
    do_cmd(3'd6, 3'd1, 8'h12, 16'h3456);
    do_cmd(3'd7, 3'd0, 8'h00, 16'h0000);
    // mixed traffic after rejects
    recv_pat = 64'h0102_0304_0506_0708;
    do_cmd(3'd2, 3'd4, 8'h00, 16'h0000);

    repeat (10) @(negedge clk);
    check("R1 scoreboard drained", 68'(exp_tx.size() + exp_rsp.size()), '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule